// File: doc/BRIEF.md
# Real-Time Clock Interrupt Event Logic

This block gathers the three interrupt sources of a real-time clock and turns them into one active-low interrupt request. The first source is a periodic event. It is taken from a free-running divider that counts enable pulses of the 32.768 kHz time base, and a four-bit rate code selects its period. The second source is an alarm event. At every end-of-update pulse it compares the current hours, minutes and seconds with three alarm bytes, and any alarm byte can be marked as matching everything. The third source is the end-of-update pulse itself.

Each source sets its own sticky flag. A request flag is set when a set event flag meets its enable bit, and the interrupt pin is pulled low for as long as the request flag stays set. Software reads an eight-bit status word. When the read strobe ends, all flags clear and the pin is released. A small enable register holds the three enable bits and a transfer-inhibit bit. The timekeeping counters and the processor bus timing are outside this block: it receives the current time and a single update-ended pulse.

Top module: `rtc_evt_irq`

## Requirements
- R1: For rate codes 3 to 15, the periodic flag sets on every tick whose count since reset is a multiple of 2^(code-1). The tick counter runs freely from reset and wraps at 2^14.
- R2: Rate code 0 produces no periodic event. Code 1 behaves like code 8 (period 128 ticks) and code 2 behaves like code 9 (period 256 ticks).
- R3: On an update-ended pulse, the alarm flag sets when all three alarm bytes match the current hour, minute and second. It does not set on a mismatch, and it does not change except on an update pulse or a flag clear.
- R4: An alarm byte whose bits 7:6 are both 1 matches any value. This gives alarms once per second, minute, hour or day, depending on which bytes are marked this way.
- R5: Every update-ended pulse sets the update flag.
- R6: The status word holds the request flag in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. Bits 3:0 always read 0.
- R7: The request flag sets when any event flag is 1 together with its enable bit. This also happens when the enable is written after the flag was already set. irqLowEn equals the request flag.
- R8: During a status read, statData shows the flags as they were before clearing. All four flags clear at the clock edge after statRd falls, which releases irqLowEn. An event that arrives in that same clearing cycle is kept.
- R9: The update source raises a request only when its enable is 1 and transfer-inhibit is 0. Writing transfer-inhibit as 1 forces the update enable to 0.
- R10: Reset clears all flags, all enable bits and transfer-inhibit, and it releases irqLowEn.
- R11: The enable register is laid out as bit 3 transfer-inhibit, bit 2 periodic enable, bit 1 alarm enable and bit 0 update enable. It can be read back on cfgQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle enable pulse per 32.768 kHz period |
| rateSel | input | 4 | Periodic rate code |
| updEnd | input | 1 | One-cycle pulse at the end of a time update |
| curSec | input | 8 | Current seconds byte |
| curMin | input | 8 | Current minutes byte |
| curHour | input | 8 | Current hours byte |
| almSec | input | 8 | Seconds alarm byte |
| almMin | input | 8 | Minutes alarm byte |
| almHour | input | 8 | Hours alarm byte |
| cfgWr | input | 1 | Enable register write strobe |
| cfgData | input | 4 | Enable register write data |
| cfgQ | output | 4 | Enable register contents |
| statRd | input | 1 | Status read strobe, level-sensitive |
| statData | output | 8 | Status word |
| irqLowEn | output | 1 | 1 = interrupt pin driven low, 0 = released (high impedance) |

## Verification
The hardest situations to reach from the ports are the exact tick on which a slow periodic rate fires, and an event that lands in the very cycle a status read ends. For every rate code, the stimulus tracks its own tick count since reset. It runs ticks up to one tick before the next multiple of the period and checks that no flag is set, then adds one tick and checks that the flag appears. A directed read drops statRd in the same cycle that it pulses updEnd, so the bench can check that the new update flag survives the clear. Randomized alarm bytes, each set to equal, don't-care or different, cover the match patterns.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;

  // number of event sources: periodic, alarm, update
  localparam int EVT_NUM = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic clrFlags;
    logic updEvt;
  } ctlStrobe_t;

  // enable register contents
  typedef struct packed {
    logic inhibit;
    logic perEn;
    logic almEn;
    logic updEn;
  } evtEn_t;

endpackage

// File: rtl/rtc_evt_ctl.sv
module rtc_evt_ctl
  import rtc_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  logic [3:0] cfgData,
  input  logic       statRd,
  input  logic       updEnd,
  output ctlStrobe_t stb,
  output evtEn_t     en
);

  logic statRdQ;

  always_ff @(posedge clk) begin
    if (!rstN) statRdQ <= 1'b0;
    else       statRdQ <= statRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en <= '0;
    end else if (cfgWr) begin
      en.inhibit <= cfgData[3];
      en.perEn   <= cfgData[2];
      en.almEn   <= cfgData[1];
      en.updEn   <= cfgData[0] & ~cfgData[3];
    end
  end

  always_comb begin
    stb.clrFlags = statRdQ & ~statRd;
    stb.updEvt   = updEnd;
  end

  // R9
  uie_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr && cfgData[3] |=> !en.updEn);

endmodule

// File: rtl/rtc_evt_div.sv
module rtc_evt_div #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [RATE_W-1:0] rateSel,
  output logic              perEvt
);

  localparam int CODE_N    = 1 << RATE_W;
  localparam int DIV_W     = CODE_N - 2;
  localparam int ALIAS_OFS = 7;

  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  cntNext;
  logic [CODE_N-1:0] tapHit;

  assign cntNext = divCnt + DIV_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)       divCnt <= '0;
    else if (tickEn) divCnt <= cntNext;
  end

  assign tapHit[0] = 1'b0;

  for (genvar i = 1; i < CODE_N; i++) begin : g_tap
    localparam int EXPO = (i < 3) ? i + ALIAS_OFS : i;
    localparam int LOWB = EXPO - 1;
    assign tapHit[i] = ~|cntNext[LOWB-1:0];
  end

  assign perEvt = tickEn & tapHit[rateSel];

  // R2
  no_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    rateSel == '0 |-> !perEvt);

endmodule

// File: rtl/rtc_evt_dp.sv
module rtc_evt_dp
  import rtc_evt_pkg::*;
#(
  parameter int TIME_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  perEvt,
  input  ctlStrobe_t            stb,
  input  evtEn_t                en,
  input  logic [3*TIME_W-1:0]   curTime,
  input  logic [3*TIME_W-1:0]   almTime,
  output logic [EVT_NUM-1:0]    flagsQ,
  output logic                  intfQ
);

  logic [2:0]         byteHit;
  logic               almEvt;
  logic [EVT_NUM-1:0] evtVec;
  logic [EVT_NUM-1:0] enMask;
  logic [EVT_NUM-1:0] flagsD;
  logic               intfD;

  for (genvar b = 0; b < 3; b++) begin : g_cmp
    logic [TIME_W-1:0] curB;
    logic [TIME_W-1:0] almB;
    assign curB = curTime[b*TIME_W +: TIME_W];
    assign almB = almTime[b*TIME_W +: TIME_W];
    assign byteHit[b] = (almB[TIME_W-1 -: 2] == 2'b11) | (almB == curB);
  end

  assign almEvt = stb.updEvt & (&byteHit);
  assign evtVec = {perEvt, almEvt, stb.updEvt};
  assign enMask = {en.perEn, en.almEn, en.updEn & ~en.inhibit};

  always_comb begin
    flagsD = (stb.clrFlags ? '0 : flagsQ) | evtVec;
    intfD  = (stb.clrFlags ? 1'b0 : intfQ) | (|(flagsD & enMask));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
      intfQ  <= 1'b0;
    end else begin
      flagsQ <= flagsD;
      intfQ  <= intfD;
    end
  end

  // R5
  upd_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.updEvt |=> flagsQ[0]);

  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrFlags && !(|evtVec) |=> flagsQ == '0 && !intfQ);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(flagsQ & enMask)) && !stb.clrFlags |=> intfQ);

  // R3
  alm_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.updEvt && !stb.clrFlags |=> $stable(flagsQ[1]));

endmodule

// File: rtl/rtc_evt_irq.sv
module rtc_evt_irq
  import rtc_evt_pkg::*;
#(
  parameter int TIME_W = 8,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              updEnd,
  input  logic [TIME_W-1:0] curSec,
  input  logic [TIME_W-1:0] curMin,
  input  logic [TIME_W-1:0] curHour,
  input  logic [TIME_W-1:0] almSec,
  input  logic [TIME_W-1:0] almMin,
  input  logic [TIME_W-1:0] almHour,
  input  logic              cfgWr,
  input  logic [3:0]        cfgData,
  output logic [3:0]        cfgQ,
  input  logic              statRd,
  output logic [7:0]        statData,
  output logic              irqLowEn
);

  ctlStrobe_t         stb;
  evtEn_t             en;
  logic               perEvt;
  logic [EVT_NUM-1:0] flagsQ;
  logic               intfQ;

  rtc_evt_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWr   (cfgWr),
    .cfgData (cfgData),
    .statRd  (statRd),
    .updEnd  (updEnd),
    .stb     (stb),
    .en      (en)
  );

  rtc_evt_div #(.RATE_W(RATE_W)) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .rateSel (rateSel),
    .perEvt  (perEvt)
  );

  rtc_evt_dp #(.TIME_W(TIME_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .perEvt  (perEvt),
    .stb     (stb),
    .en      (en),
    .curTime ({curHour, curMin, curSec}),
    .almTime ({almHour, almMin, almSec}),
    .flagsQ  (flagsQ),
    .intfQ   (intfQ)
  );

  assign statData = {intfQ, flagsQ, 4'b0000};
  assign cfgQ     = {en.inhibit, en.perEn, en.almEn, en.updEn};
  assign irqLowEn = intfQ;

endmodule

// File: tb/sim_rtc_evt_irq.sv
`timescale 1ns/1ps
module sim_rtc_evt_irq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [3:0] rateSel = 4'd0;
  logic       updEnd = 1'b0;
  logic [7:0] curSec = '0, curMin = '0, curHour = '0;
  logic [7:0] almSec = '0, almMin = '0, almHour = '0;
  logic       cfgWr = 1'b0;
  logic [3:0] cfgData = '0;
  logic [3:0] cfgQ;
  logic       statRd = 1'b0;
  logic [7:0] statData;
  logic       irqLowEn;

  int checks = 0;
  int errors = 0;
  int tickCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_evt_irq u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rateSel(rateSel), .updEnd(updEnd),
    .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .almSec(almSec), .almMin(almMin), .almHour(almHour),
    .cfgWr(cfgWr), .cfgData(cfgData), .cfgQ(cfgQ),
    .statRd(statRd), .statData(statData), .irqLowEn(irqLowEn)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit almByteHit(logic [7:0] cur, logic [7:0] alm);
    return (alm[7:6] == 2'b11) || (alm == cur);
  endfunction

  function automatic int periodOf(int code);
    int e;
    e = (code < 3) ? code + 7 : code;
    return 1 << (e - 1);
  endfunction

  task automatic doRead(output logic [7:0] v);
    @(negedge clk) statRd = 1'b1;
    #1 v = statData;
    @(negedge clk) statRd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wrCfg(logic [3:0] d);
    @(negedge clk) begin cfgWr = 1'b1; cfgData = d; end
    @(negedge clk) cfgWr = 1'b0;
  endtask

  task automatic pulseUpd(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    @(negedge clk) begin curHour = h; curMin = m; curSec = s; updEnd = 1'b1; end
    @(negedge clk) updEnd = 1'b0;
  endtask

  task automatic runTicks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tickEn = 1'b1;
      tickCnt++;
    end
    @(negedge clk) tickEn = 1'b0;
  endtask

  initial begin
    #950000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] seedv;
    seedv = 8'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 status after reset", statData, 8'h00);
    chk("R10 cfg after reset", {4'h0, cfgQ}, 8'h00);
    chk("R10 irq after reset", {7'd0, irqLowEn}, 8'h00);

    // R11 layout, R9 inhibit clears update enable
    wrCfg(4'h7);
    chk("R11 cfg readback", {4'h0, cfgQ}, 8'h07);
    wrCfg(4'hF);
    chk("R9 inhibit clears upd enable", {4'h0, cfgQ}, 8'h0E);

    // R5 update flag without request while inhibited
    pulseUpd(8'h01, 8'h02, 8'h03);
    chk("R5 R9 upd flag no request", statData, 8'h10);
    chk("R9 irq released under inhibit", {7'd0, irqLowEn}, 8'h00);
    doRead(rv);
    chk("R8 read value", rv, 8'h10);
    chk("R8 flags cleared", statData, 8'h00);

    // R7 update request enabled
    wrCfg(4'h1);
    pulseUpd(8'h01, 8'h02, 8'h04);
    chk("R7 upd request", statData, 8'h90);
    chk("R7 irq low", {7'd0, irqLowEn}, 8'h01);
    doRead(rv);
    chk("R8 read before clear", rv, 8'h90);
    chk("R8 cleared after read", statData, 8'h00);
    chk("R8 irq released", {7'd0, irqLowEn}, 8'h00);

    // R3 R4 alarm compare, random bytes with don't-care marking
    wrCfg(4'h2);
    for (int it = 0; it < 48; it++) begin
      logic [7:0] cv [3];
      logic [7:0] av [3];
      bit hit;
      int mode;
      cv[0] = 8'($urandom % 60);
      cv[1] = 8'($urandom % 60);
      cv[2] = 8'($urandom % 24);
      for (int b = 0; b < 3; b++) begin
        mode = (it < 8) ? ((it >> b) & 1) : int'($urandom % 3);
        if (mode == 0)      av[b] = cv[b];
        else if (mode == 1) av[b] = 8'hC0 | 8'($urandom % 64);
        else                av[b] = cv[b] ^ 8'(1 + ($urandom % 63));
      end
      almSec = av[0]; almMin = av[1]; almHour = av[2];
      hit = almByteHit(cv[0], av[0]) && almByteHit(cv[1], av[1]) && almByteHit(cv[2], av[2]);
      pulseUpd(cv[2], cv[1], cv[0]);
      chk("R3 R4 alarm status", statData, {hit, 1'b0, hit, 1'b1, 4'h0});
      chk("R7 alarm irq", {7'd0, irqLowEn}, {7'd0, hit});
      doRead(rv);
    end

    // R8 event in the clearing cycle is kept
    wrCfg(4'h0);
    @(negedge clk) statRd = 1'b1;
    @(negedge clk) begin statRd = 1'b0; updEnd = 1'b1; end
    @(negedge clk) updEnd = 1'b0;
    chk("R8 event in clear cycle kept", statData, 8'h10);
    doRead(rv);

    // R7 enable written after flag set
    rateSel = 4'd3;
    runTicks(4);
    chk("R7 flag without enable", statData, 8'h40);
    wrCfg(4'h4);
    @(negedge clk);
    chk("R7 late enable raises request", statData, 8'hC0);
    chk("R7 late enable irq", {7'd0, irqLowEn}, 8'h01);
    doRead(rv);

    // R1 R2 exact period boundary for every code, periodic enable on
    for (int code = 0; code < 16; code++) begin
      rateSel = 4'(code);
      doRead(rv);
      if (code == 0) begin
        runTicks(300);
        chk("R2 code 0 silent", statData, 8'h00);
      end else begin
        int p, r;
        p = periodOf(code);
        r = tickCnt % p;
        if (p - r - 1 > 0) runTicks(p - r - 1);
        chk(code < 3 ? "R2 alias before boundary" : "R1 before boundary", statData, 8'h00);
        runTicks(1);
        chk(code < 3 ? "R2 alias at boundary" : "R1 at boundary", statData, 8'hC0);
        chk("R7 periodic irq", {7'd0, irqLowEn}, 8'h01);
      end
    end

    // R1 random run lengths
    for (int it = 0; it < 30; it++) begin
      int code, p, n, t0;
      bit fire;
      code = 1 + int'($urandom % 10);
      rateSel = 4'(code);
      doRead(rv);
      p = periodOf(code);
      n = 1 + int'($urandom % (2 * p));
      t0 = tickCnt;
      runTicks(n);
      fire = ((t0 + n) / p) > (t0 / p);
      chk("R1 random periodic", statData, {fire, fire, 6'd0});
    end
    doRead(rv);

    // R6 status low bits and layout with all flags set
    wrCfg(4'h7);
    rateSel = 4'd3;
    almSec = 8'hFF; almMin = 8'hFF; almHour = 8'hFF;
    runTicks(4);
    pulseUpd(8'h05, 8'h06, 8'h07);
    chk("R6 full status layout", statData, 8'hF0);

    // R10 reset with flags set
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    tickCnt = 0;
    @(negedge clk);
    chk("R10 status after mid reset", statData, 8'h00);
    chk("R10 cfg after mid reset", {4'h0, cfgQ}, 8'h00);
    chk("R10 irq after mid reset", {7'd0, irqLowEn}, 8'h00);

    if (seedv === 8'hxx) errors++;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule